// File: doc/BRIEF.md
# Parallel-Bus Transfer Timing Calculator

This block turns a storage-device programmed-I/O transfer mode (0 to 6) and a clock rate, given as whole clock cycles per microsecond, into the cycle counts that a programmable bus-timing register expects. It looks up three nanosecond timings for the selected mode: address-to-strobe setup, strobe width, and recovery hold. It converts each timing into clock cycles with a ceiling divide and stores the result in minus-one form. It then halves the counts repeatedly until they fit, tracking a power-of-two time multiplier.

A one-cycle start pulse captures the mode and the clock rate. The block then works through the three timings one at a time using a shared iterative divider. When the results are ready, it drives all fields together with a one-cycle done pulse. The fields keep those values until the next run completes.

Top module: `pio_timing_calc`

## Requirements
- R1: After reset `busy`, `done`, `iordy_en`, `mult_code` and all three cycle fields are 0.
- R2: Each timing in cycles is ceil(ns × rate / 1000). The nanosecond triples (setup, strobe, recover) are:
  - mode 6: (10, 55, 10)
  - mode 5: (15, 65, 10)
  - mode 4: (25, 70, 10)
  - mode 3: (30, 80, 10)
  - mode 2: (30, 100, 10)
  - mode 1: (50, 125, 15)
  - mode 0: (70, 165, 20)
- R3: A nonzero converted count is reduced by one before scaling. A count of zero stays zero.
- R4: While the strobe count is 64 or more, every count becomes ceil(count/2) and the multiplier doubles, starting from 1. The final strobe count is below 64.
- R5: `mult_code` encodes the multiplier as 1→1, 2→2, 4→0, and 8 or more→3.
- R6: `iordy_en` is 1 for modes 0 to 4 and 0 for modes 5 and 6.
- R7: Mode value 7 uses the mode 0 timings and sets `iordy_en` to 1.
- R8: A `start` pulse while `busy` is 1 is ignored. The running computation finishes with the inputs captured at its own start.
- R9: `done` is high for exactly one cycle, with the new fields. The fields do not change in any other cycle.
- R10: The captured rate is clamped to the range 1 to 1000. Rate 0 behaves as 1, and any rate above 1000 behaves as 1000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Capture inputs and begin a computation |
| mode_sel | input | 3 | Transfer mode number |
| clk_per_us | input | 11 | Clock cycles per microsecond |
| busy | output | 1 | Computation in progress |
| done | output | 1 | One-cycle result-valid pulse |
| mult_code | output | 2 | Encoded time multiplier |
| setup_cyc | output | 6 | Setup count, minus-one form |
| strobe_cyc | output | 6 | Strobe-width count, minus-one form |
| recover_cyc | output | 6 | Recovery count, minus-one form |
| iordy_en | output | 1 | Device ready flow control in use |

## Verification
The bench builds the block with its default parameters. These are an 8-bit nanosecond width, an 11-bit rate input, a 19-bit product and 6-bit fields. With these values, rates between 1 and 1000 reach the multipliers 1, 2 and 4. Rates of 100, 333, 600, 700 and 1000 cover no scaling, one halving and two halvings. They also cover exact and rounded-up divisions. Rate 1 and rate 0 drive every count to zero, and an oversized rate shows the clamp.

// File: rtl/pio_timing_pkg.sv
package pio_timing_pkg;

    localparam int NS_W    = 8;
    localparam int RATE_W  = 11;
    localparam int PROD_W  = NS_W + RATE_W;
    localparam int FIELD_W = 6;
    localparam int NPARAM  = 3;
    localparam int RATE_MAX = 1000;
    localparam int NS_PER_US = 1000;

    typedef struct packed {
        logic [NS_W-1:0] setup_ns;
        logic [NS_W-1:0] strobe_ns;
        logic [NS_W-1:0] recover_ns;
        logic            iordy;
    } mode_row_t;

    typedef enum logic [2:0] {
        ST_IDLE, ST_KICK, ST_WAIT, ST_SCALE
    } calc_state_t;

    function automatic mode_row_t mode_row(input logic [2:0] m);
        mode_row_t r;
        case (m)
            3'd1:    r = '{8'd50, 8'd125, 8'd15, 1'b1};
            3'd2:    r = '{8'd30, 8'd100, 8'd10, 1'b1};
            3'd3:    r = '{8'd30, 8'd80,  8'd10, 1'b1};
            3'd4:    r = '{8'd25, 8'd70,  8'd10, 1'b1};
            3'd5:    r = '{8'd15, 8'd65,  8'd10, 1'b0};
            3'd6:    r = '{8'd10, 8'd55,  8'd10, 1'b0};
            default: r = '{8'd70, 8'd165, 8'd20, 1'b1};
        endcase
        return r;
    endfunction

    function automatic logic [1:0] mult_encode(input logic [1:0] halvings);
        case (halvings)
            2'd0:    return 2'd1;
            2'd1:    return 2'd2;
            2'd2:    return 2'd0;
            default: return 2'd3;
        endcase
    endfunction

endpackage

// File: rtl/pio_ceil_div.sv
module pio_ceil_div #(
    parameter int NUM_W = 19,
    parameter int DEN_W = 11
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic [NUM_W-1:0] dividend,
    input  logic [DEN_W-1:0] divisor,
    output logic             done,
    output logic [NUM_W-1:0] quot,
    output logic [DEN_W-1:0] rem
);
    localparam int ACC_W = DEN_W + 1;
    localparam int STEP_W = $clog2(NUM_W + 1);

    logic [NUM_W-1:0]  shq;
    logic [ACC_W-1:0]  acc;
    logic [DEN_W-1:0]  den_q;
    logic [STEP_W-1:0] steps;
    logic              running;
    logic [ACC_W-1:0]  trial;
    logic              fits;

    assign trial = {acc[ACC_W-2:0], shq[NUM_W-1]};
    assign fits  = trial >= ACC_W'(den_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            shq     <= '0;
            acc     <= '0;
            den_q   <= '0;
            steps   <= '0;
            running <= 1'b0;
            done    <= 1'b0;
        end else begin
            done <= 1'b0;
            if (start && !running) begin
                shq     <= dividend;
                acc     <= '0;
                den_q   <= divisor;
                steps   <= STEP_W'(NUM_W);
                running <= 1'b1;
            end else if (running) begin
                acc   <= fits ? trial - ACC_W'(den_q) : trial;
                shq   <= {shq[NUM_W-2:0], fits};
                steps <= steps - 1'b1;
                if (steps == STEP_W'(1)) begin
                    running <= 1'b0;
                    done    <= 1'b1;
                end
            end
        end
    end

    assign quot = shq;
    assign rem  = acc[DEN_W-1:0];

    // R2
    rem_bound_chk: assert property (@(posedge clk) disable iff (rst)
        done |-> (acc < ACC_W'(den_q)));

    // R2
    div_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

endmodule

// File: rtl/pio_timing_calc.sv
module pio_timing_calc
    import pio_timing_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               start,
    input  logic [2:0]         mode_sel,
    input  logic [RATE_W-1:0]  clk_per_us,
    output logic               busy,
    output logic               done,
    output logic [1:0]         mult_code,
    output logic [FIELD_W-1:0] setup_cyc,
    output logic [FIELD_W-1:0] strobe_cyc,
    output logic [FIELD_W-1:0] recover_cyc,
    output logic               iordy_en
);
    localparam int IDX_W = $clog2(NPARAM);
    localparam logic [PROD_W-1:0] FIT_LIMIT = PROD_W'(1) << FIELD_W;

    calc_state_t       state;
    mode_row_t         row_q;
    logic [RATE_W-1:0] rate_q;
    logic [IDX_W-1:0]  idx;
    logic [PROD_W-1:0] cnt [NPARAM];
    logic [1:0]        halvings;

    logic              dv_start, dv_done;
    logic [PROD_W-1:0] dv_num, dv_quot;
    logic [RATE_W-1:0] dv_rem;
    logic [NS_W-1:0]   cur_ns;
    logic [PROD_W-1:0] rounded;
    logic [RATE_W-1:0] rate_clamped;

    always_comb begin
        if (clk_per_us == '0)
            rate_clamped = RATE_W'(1);
        else if (clk_per_us > RATE_W'(RATE_MAX))
            rate_clamped = RATE_W'(RATE_MAX);
        else
            rate_clamped = clk_per_us;
    end

    always_comb begin
        case (idx)
            IDX_W'(0): cur_ns = row_q.setup_ns;
            IDX_W'(1): cur_ns = row_q.strobe_ns;
            default:   cur_ns = row_q.recover_ns;
        endcase
    end

    assign dv_start = (state == ST_KICK);
    assign dv_num   = PROD_W'(cur_ns) * PROD_W'(rate_q);
    assign rounded  = dv_quot + PROD_W'(dv_rem != '0);

    pio_ceil_div #(.NUM_W(PROD_W), .DEN_W(RATE_W)) div_i (
        .clk      (clk),
        .rst      (rst),
        .start    (dv_start),
        .dividend (dv_num),
        .divisor  (RATE_W'(NS_PER_US)),
        .done     (dv_done),
        .quot     (dv_quot),
        .rem      (dv_rem)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state       <= ST_IDLE;
            row_q       <= '0;
            rate_q      <= '0;
            idx         <= '0;
            halvings    <= '0;
            done        <= 1'b0;
            mult_code   <= '0;
            setup_cyc   <= '0;
            strobe_cyc  <= '0;
            recover_cyc <= '0;
            iordy_en    <= 1'b0;
            for (int i = 0; i < NPARAM; i++) cnt[i] <= '0;
        end else begin
            done <= 1'b0;
            case (state)
                ST_IDLE: if (start) begin
                    row_q    <= mode_row(mode_sel);
                    rate_q   <= rate_clamped;
                    idx      <= '0;
                    halvings <= '0;
                    state    <= ST_KICK;
                end
                ST_KICK: state <= ST_WAIT;
                ST_WAIT: if (dv_done) begin
                    cnt[idx] <= (rounded == '0) ? '0 : rounded - 1'b1;
                    if (idx == IDX_W'(NPARAM - 1)) begin
                        state <= ST_SCALE;
                    end else begin
                        idx   <= idx + 1'b1;
                        state <= ST_KICK;
                    end
                end
                ST_SCALE: if (cnt[1] >= FIT_LIMIT) begin
                    for (int i = 0; i < NPARAM; i++)
                        cnt[i] <= (cnt[i] >> 1) + PROD_W'(cnt[i][0]);
                    if (halvings != 2'd3) halvings <= halvings + 1'b1;
                end else begin
                    setup_cyc   <= cnt[0][FIELD_W-1:0];
                    strobe_cyc  <= cnt[1][FIELD_W-1:0];
                    recover_cyc <= cnt[2][FIELD_W-1:0];
                    mult_code   <= mult_encode(halvings);
                    iordy_en    <= row_q.iordy;
                    done        <= 1'b1;
                    state       <= ST_IDLE;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    assign busy = (state != ST_IDLE);

    // R9
    done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R9
    field_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !done |-> ($stable(strobe_cyc) && $stable(setup_cyc) && $stable(recover_cyc)
                   && $stable(mult_code) && $stable(iordy_en)));

    // R8
    busy_entry_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> $past(start));

    // R4
    fit_chk: assert property (@(posedge clk) disable iff (rst)
        (state == ST_SCALE && halvings == 2'd3) |-> (cnt[1] < FIT_LIMIT));

    // R10
    rate_range_chk: assert property (@(posedge clk) disable iff (rst)
        busy |-> (rate_q >= RATE_W'(1) && rate_q <= RATE_W'(RATE_MAX)));

endmodule

// File: tb/pio_timing_calc_tb.sv
module pio_timing_calc_tb_top;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic [2:0]  mode_sel = '0;
    logic [10:0] clk_per_us = '0;
    logic        busy, done, iordy_en;
    logic [1:0]  mult_code;
    logic [5:0]  setup_cyc, strobe_cyc, recover_cyc;

    int n_checks = 0;
    int n_bad = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    pio_timing_calc dut_i (
        .clk(clk), .rst(rst), .start(start), .mode_sel(mode_sel),
        .clk_per_us(clk_per_us), .busy(busy), .done(done),
        .mult_code(mult_code), .setup_cyc(setup_cyc), .strobe_cyc(strobe_cyc),
        .recover_cyc(recover_cyc), .iordy_en(iordy_en)
    );

    task automatic check(input string req, input string what, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    function automatic int ceil_div(input int a, input int b);
        return (a + b - 1) / b;
    endfunction

    // Expected results from the requirement text (R2..R7, R10)
    task automatic expect_vals(input int mode, input int rate,
                               output int e_s, output int e_t, output int e_r,
                               output int e_code, output int e_rdy);
        int ns_s, ns_t, ns_r, r, mult;
        case (mode)
            1: begin ns_s = 50; ns_t = 125; ns_r = 15; end
            2: begin ns_s = 30; ns_t = 100; ns_r = 10; end
            3: begin ns_s = 30; ns_t = 80;  ns_r = 10; end
            4: begin ns_s = 25; ns_t = 70;  ns_r = 10; end
            5: begin ns_s = 15; ns_t = 65;  ns_r = 10; end
            6: begin ns_s = 10; ns_t = 55;  ns_r = 10; end
            default: begin ns_s = 70; ns_t = 165; ns_r = 20; end
        endcase
        r = (rate < 1) ? 1 : (rate > 1000) ? 1000 : rate;
        e_s = ceil_div(ns_s * r, 1000); if (e_s > 0) e_s--;
        e_t = ceil_div(ns_t * r, 1000); if (e_t > 0) e_t--;
        e_r = ceil_div(ns_r * r, 1000); if (e_r > 0) e_r--;
        mult = 1;
        while (e_t >= 64) begin
            e_s = ceil_div(e_s, 2); e_t = ceil_div(e_t, 2); e_r = ceil_div(e_r, 2);
            mult = mult * 2;
        end
        e_code = (mult == 1) ? 1 : (mult == 2) ? 2 : (mult == 4) ? 0 : 3;
        e_rdy = (mode == 5 || mode == 6) ? 0 : 1;
    endtask

    task automatic pulse_start(input int mode, input int rate);
        @(negedge clk);
        mode_sel = 3'(mode);
        clk_per_us = 11'(rate);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic wait_done(input string req);
        int n = 0;
        while (done !== 1'b1 && n < 500) begin
            @(negedge clk);
            n++;
        end
        check(req, "done seen", int'(done === 1'b1), 1);
    endtask

    task automatic compare(input string req, input int mode, input int rate);
        int e_s, e_t, e_r, e_code, e_rdy;
        expect_vals(mode, rate, e_s, e_t, e_r, e_code, e_rdy);
        check(req, "setup", int'(setup_cyc), e_s);
        check(req, "strobe", int'(strobe_cyc), e_t);
        check(req, "recover", int'(recover_cyc), e_r);
        check(req, "mult_code", int'(mult_code), e_code);
        check(req, "iordy_en", int'(iordy_en), e_rdy);
    endtask

    task automatic run_case(input string req, input int mode, input int rate);
        pulse_start(mode, rate);
        wait_done(req);
        compare(req, mode, rate);
        @(negedge clk);
        check(req, "done one cycle", int'(done), 0);
    endtask

    task automatic test_reset();
        check("R1", "busy", int'(busy), 0);
        check("R1", "done", int'(done), 0);
        check("R1", "mult_code", int'(mult_code), 0);
        check("R1", "setup", int'(setup_cyc), 0);
        check("R1", "strobe", int'(strobe_cyc), 0);
        check("R1", "recover", int'(recover_cyc), 0);
        check("R1", "iordy_en", int'(iordy_en), 0);
    endtask

    task automatic test_modes();
        run_case("R2", 6, 100);   // R2 R6: small counts, no scaling
        run_case("R3", 3, 600);   // R3
        run_case("R2", 2, 333);   // R2: rounded-up division
        run_case("R4", 1, 700);   // R4 R5: one halving, multiplier 2
        run_case("R5", 0, 1000);  // R5: two halvings, multiplier 4
        run_case("R6", 5, 1000);  // R6: iordy off
        run_case("R6", 4, 250);
        run_case("R7", 7, 1000);  // R7: unlisted mode uses mode 0
    endtask

    task automatic test_clamp();
        run_case("R10", 0, 0);     // R10: rate 0 acts as 1
        run_case("R3", 0, 1);      // R3: every count becomes zero
        run_case("R10", 1, 2000);  // R10: clamped to 1000
    endtask

    task automatic test_busy_ignore();
        pulse_start(4, 900);
        repeat (5) @(negedge clk);
        check("R8", "busy mid-run", int'(busy), 1);
        mode_sel = 3'd6; clk_per_us = 11'd50; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        wait_done("R8");
        compare("R8", 4, 900);
    endtask

    task automatic test_hold();
        int s0, t0, r0, c0;
        run_case("R9", 2, 800);
        s0 = int'(setup_cyc); t0 = int'(strobe_cyc); r0 = int'(recover_cyc); c0 = int'(mult_code);
        mode_sel = 3'd6; clk_per_us = 11'd10;
        repeat (20) @(negedge clk);
        check("R9", "hold setup", int'(setup_cyc), s0);
        check("R9", "hold strobe", int'(strobe_cyc), t0);
        check("R9", "hold recover", int'(recover_cyc), r0);
        check("R9", "hold mult", int'(mult_code), c0);
        check("R9", "no done", int'(done), 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        test_reset();
        test_modes();
        test_clamp();
        test_busy_ignore();
        test_hold();
        $display("test done: total=%0d bad=%0d", n_checks, n_bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_checks++;
        n_bad++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("test done: total=%0d bad=%0d", n_checks, n_bad);
        $finish;
    end

endmodule